// File: doc/BRIEF.md
# Shutdown Wake and Pin Retention Controller

This block is the always-on part of a low-power shutdown scheme for a bank of general-purpose pins. While the core runs, software programs each pin's wake enable and wake polarity. The pad outputs and output enables follow the core's values through one register stage. A shutdown command copies the wake settings into always-on shadow storage. It freezes the pad outputs and enables at the values the core drives in that cycle, and it clears the core-domain configuration registers, which lose power.

In shutdown the block waits for one of three exit conditions: an enabled pin at its programmed level, an external reset request, or a debug request. It then drives a core reset pulse of fixed length, sets an exit-cause flag, and records in per-pin sticky flags which pins matched. The pads stay frozen through that reset until software writes a release pulse. The flags and the cause survive the core reset, and software clears them with write-one-to-clear pulses. A shutdown command is refused, and a status bit is set, when an enabled pin already matches its wake level.

Top module: `shw_ctrl`

## Requirements
- R1: After the synchronous reset `rst`: `pad_out`, `pad_oe`, `wake_en_q`, `wake_pol_q` and `wake_flags` are all zero, and `core_rst`, `in_shdn`, `io_frozen`, `exit_cause` and `shdn_rej` are 0.
- R2: While running and not frozen, `pad_out`/`pad_oe` equal the `core_out`/`core_oe` of the previous cycle. A `cfg_we` cycle loads `wake_en_q`/`wake_pol_q` from `cfg_wake_en`/`cfg_wake_pol`.
- R3: A `shdn_cmd` in the running state, with no enabled pin matching (pin i matches when `wake_en_q[i]`=1 and `pin_in[i]`==`wake_pol_q[i]`), gives `in_shdn`=1 and `io_frozen`=1 in the next cycle. The pads then hold the `core_out`/`core_oe` values present with the command.
- R4: A `shdn_cmd` while any enabled pin matches leaves the block running and sets `shdn_rej` to 1. An accepted command sets `shdn_rej` to 0.
- R5: In shutdown, a wake occurs only when a pin enabled before entry has a level equal to its stored polarity. Disabled pins and non-matching levels leave `in_shdn` at 1.
- R6: In shutdown, `ext_wake` or `dbg_wake` at 1 causes a wake without setting any `wake_flags` bit.
- R7: A wake raises `core_rst` in the next cycle, and `core_rst` stays high for exactly RST_CYCLES (default 8) consecutive cycles.
- R8: While `io_frozen` is 1 the pads ignore `core_out`/`core_oe`, through shutdown and through the core reset. A `io_release` pulse in the running state clears `io_frozen` in the next cycle, and the pads follow the core one cycle later. `io_release` has no effect outside the running state.
- R9: A wake sets `exit_cause` to 1. The core reset does not clear it. A `cause_clr` pulse clears it.
- R10: At a wake, bit i of `wake_flags` is set for each enabled pin that matches. The flags persist through the core reset, and each bit of `flag_clr` clears its own flag.
- R11: `wake_en_q`/`wake_pol_q` read zero from shutdown entry until the core reset ends, and `cfg_we` is ignored in that time.
- R12: `shdn_cmd` is ignored during the core reset. `ext_wake` and `dbg_wake` have no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_we | input | 1 | Write strobe for the wake configuration |
| cfg_wake_en | input | NPINS | Wake enable per pin (write data) |
| cfg_wake_pol | input | NPINS | Wake level per pin, 1 = high (write data) |
| wake_en_q | output | NPINS | Current wake enables |
| wake_pol_q | output | NPINS | Current wake levels |
| shdn_cmd | input | 1 | Shutdown request pulse |
| shdn_rej | output | 1 | Last shutdown request was refused |
| io_release | input | 1 | Unfreeze pads pulse |
| pin_in | input | NPINS | Pin levels, synchronous to clk |
| core_out | input | NPINS | Output values from the core |
| core_oe | input | NPINS | Output enables from the core |
| pad_out | output | NPINS | Output values to the pads |
| pad_oe | output | NPINS | Output enables to the pads |
| ext_wake | input | 1 | External reset request |
| dbg_wake | input | 1 | Debug connection request |
| core_rst | output | 1 | Core reset pulse after a wake |
| in_shdn | output | 1 | Block is in shutdown |
| io_frozen | output | 1 | Pad state is held |
| wake_flags | output | NPINS | Sticky per-pin wake source flags |
| flag_clr | input | NPINS | Write-one-to-clear for wake_flags |
| exit_cause | output | 1 | Sticky shutdown-exit reset cause |
| cause_clr | input | 1 | Clear pulse for exit_cause |

## Verification
The bench issues shutdown commands while pins already match, and expects a refusal. A design that entered anyway would sit in a shutdown it should leave at once, and `shdn_rej` would stay 0. In shutdown it wiggles disabled pins and holds enabled ones at the wrong level. An edge-triggered or unmasked detector would wake early. It then raises several enabled pins at once, or uses the external and debug requests, and checks the flags bit by bit.

It counts every cycle of the reset pulse to catch an off-by-one. It drives new core values and a release pulse during the freeze, so a design that leaked the core values through or cleared the hold during reset shows pad changes. Partial write-one-to-clear patterns show a clear logic that touches neighbouring flags.

// File: rtl/shw_pkg.sv
package shw_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SHDN = 2'd1,
    ST_WRST = 2'd2
  } shw_state_e;
endpackage

// File: rtl/shw_cfg_regs.sv
// Core-domain wake configuration. These registers model flops that lose
// power in shutdown, so a clear wins over a write.
module shw_cfg_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [NPINS-1:0] en_d,
  input  logic [NPINS-1:0] pol_d,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] pol_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (we) begin
      en_q  <= en_d;
      pol_q <= pol_d;
    end
  end

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (en_q == '0 && pol_q == '0));
endmodule

// File: rtl/shw_wake_detect.sv
// Level match per pin, always-on shadow of the wake settings, and the
// sticky per-pin wake flags.
module shw_wake_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             use_shadow,
  input  logic             take,
  input  logic [NPINS-1:0] cfg_en,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] flag_clr,
  output logic [NPINS-1:0] hit_vec,
  output logic             any_hit,
  output logic [NPINS-1:0] flags
);
  logic [NPINS-1:0] sh_en;
  logic [NPINS-1:0] sh_pol;

  always_ff @(posedge clk) begin
    if (rst || take) begin
      sh_en  <= '0;
      sh_pol <= '0;
    end else if (capture) begin
      sh_en  <= cfg_en;
      sh_pol <= cfg_pol;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic en_sel;
    logic pol_sel;
    assign en_sel     = use_shadow ? sh_en[i]  : cfg_en[i];
    assign pol_sel    = use_shadow ? sh_pol[i] : cfg_pol[i];
    assign hit_vec[i] = en_sel && (pin_in[i] == pol_sel);

    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else if (take && hit_vec[i])
        flags[i] <= 1'b1;
      else if (flag_clr[i])
        flags[i] <= 1'b0;
    end
  end

  assign any_hit = |hit_vec;

  p_flag_in_shadow_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> ((flags & ~$past(flags) & ~$past(sh_en)) == '0));
endmodule

// File: rtl/shw_pad_hold.sv
// Registered pad drive with a per-pin hold that keeps the last value.
module shw_pad_hold #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else if (!hold) begin
        pad_out[i] <= core_out[i];
        pad_oe[i]  <= core_oe[i];
      end
    end
  end

  p_pads_held_r8: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: rtl/shw_ctrl.sv
module shw_ctrl
  import shw_pkg::*;
#(
  parameter int NPINS      = 8,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [NPINS-1:0] cfg_wake_en,
  input  logic [NPINS-1:0] cfg_wake_pol,
  output logic [NPINS-1:0] wake_en_q,
  output logic [NPINS-1:0] wake_pol_q,
  input  logic             shdn_cmd,
  output logic             shdn_rej,
  input  logic             io_release,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic             ext_wake,
  input  logic             dbg_wake,
  output logic             core_rst,
  output logic             in_shdn,
  output logic             io_frozen,
  output logic [NPINS-1:0] wake_flags,
  input  logic [NPINS-1:0] flag_clr,
  output logic             exit_cause,
  input  logic             cause_clr
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

  shw_state_e       state;
  logic [CW-1:0]    rst_cnt;
  logic [NPINS-1:0] hit_vec;
  logic             any_hit;
  logic             run_st;
  logic             accept;
  logic             reject;
  logic             wake_go;

  assign run_st  = (state == ST_RUN);
  assign accept  = run_st && shdn_cmd && !any_hit;
  assign reject  = run_st && shdn_cmd && any_hit;
  assign wake_go = (state == ST_SHDN) && (any_hit || ext_wake || dbg_wake);
  assign in_shdn = (state == ST_SHDN);

  shw_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .we    (cfg_we && run_st),
    .en_d  (cfg_wake_en),
    .pol_d (cfg_wake_pol),
    .en_q  (wake_en_q),
    .pol_q (wake_pol_q)
  );

  shw_wake_detect #(.NPINS(NPINS)) u_wake (
    .clk        (clk),
    .rst        (rst),
    .capture    (accept),
    .use_shadow (state == ST_SHDN),
    .take       (wake_go),
    .cfg_en     (wake_en_q),
    .cfg_pol    (wake_pol_q),
    .pin_in     (pin_in),
    .flag_clr   (flag_clr),
    .hit_vec    (hit_vec),
    .any_hit    (any_hit),
    .flags      (wake_flags)
  );

  shw_pad_hold #(.NPINS(NPINS)) u_pad (
    .clk      (clk),
    .rst      (rst),
    .hold     (io_frozen),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  // Sequencer: run -> shutdown -> wake reset -> run
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      rst_cnt  <= '0;
      core_rst <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (accept) state <= ST_SHDN;
        end
        ST_SHDN: begin
          if (wake_go) begin
            state    <= ST_WRST;
            core_rst <= 1'b1;
            rst_cnt  <= CNT_LOAD;
          end
        end
        ST_WRST: begin
          if (rst_cnt == '0) begin
            state    <= ST_RUN;
            core_rst <= 1'b0;
          end else begin
            rst_cnt <= rst_cnt - 1'b1;
          end
        end
        default: begin
          state    <= ST_RUN;
          core_rst <= 1'b0;
        end
      endcase
    end
  end

  // Pad freeze, refusal status and reset cause (always-on)
  always_ff @(posedge clk) begin
    if (rst) begin
      io_frozen  <= 1'b0;
      shdn_rej   <= 1'b0;
      exit_cause <= 1'b0;
    end else begin
      if (accept)
        io_frozen <= 1'b1;
      else if (run_st && io_release)
        io_frozen <= 1'b0;

      if (accept)
        shdn_rej <= 1'b0;
      else if (reject)
        shdn_rej <= 1'b1;

      if (wake_go)
        exit_cause <= 1'b1;
      else if (cause_clr)
        exit_cause <= 1'b0;
    end
  end

  p_pulse_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> (rst_cnt == CNT_LOAD));
  p_pulse_end_r7: assert property (@(posedge clk) disable iff (rst)
    (core_rst && rst_cnt == '0) |=> !core_rst);
  p_cfg_dead_r11: assert property (@(posedge clk) disable iff (rst)
    !run_st |-> (wake_en_q == '0 && wake_pol_q == '0));
  p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    reject |=> (state == ST_RUN && shdn_rej));
  p_cause_set_r9: assert property (@(posedge clk) disable iff (rst)
    wake_go |=> exit_cause);
  p_flag_origin_r10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SHDN) |=> ((wake_flags & ~$past(wake_flags)) == '0));
  p_hold_outside_run_r8: assert property (@(posedge clk) disable iff (rst)
    !run_st |-> io_frozen);
endmodule

// File: tb/tb_shw_ctrl.sv
module tb_shw_ctrl;
  localparam int  N    = 8;
  localparam int  RC   = 8;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst, cfg_we, shdn_cmd, io_release, ext_wake, dbg_wake, cause_clr;
  logic [N-1:0] cfg_wake_en, cfg_wake_pol, pin_in, core_out, core_oe, flag_clr;
  logic [N-1:0] wake_en_q, wake_pol_q, pad_out, pad_oe, wake_flags;
  logic shdn_rej, core_rst, in_shdn, io_frozen, exit_cause;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  shw_ctrl #(.NPINS(N), .RST_CYCLES(RC)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wake_en(cfg_wake_en),
    .cfg_wake_pol(cfg_wake_pol), .wake_en_q(wake_en_q), .wake_pol_q(wake_pol_q),
    .shdn_cmd(shdn_cmd), .shdn_rej(shdn_rej), .io_release(io_release),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .ext_wake(ext_wake), .dbg_wake(dbg_wake),
    .core_rst(core_rst), .in_shdn(in_shdn), .io_frozen(io_frozen),
    .wake_flags(wake_flags), .flag_clr(flag_clr), .exit_cause(exit_cause),
    .cause_clr(cause_clr)
  );

  function automatic logic [N-1:0] match_of(logic [N-1:0] en, logic [N-1:0] pol,
                                             logic [N-1:0] pins);
    return en & ~(pins ^ pol);
  endfunction

  function automatic logic [N-1:0] quiet_pins(logic [N-1:0] en, logic [N-1:0] pol,
                                               logic [N-1:0] rnd);
    return (~pol & en) | (rnd & ~en);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    rst = 1; cfg_we = 0; shdn_cmd = 0; io_release = 0; ext_wake = 0; dbg_wake = 0;
    cause_clr = 0; cfg_wake_en = '0; cfg_wake_pol = '0; pin_in = '0;
    core_out = '1; core_oe = '1; flag_clr = '0;
    repeat (3) tick();
    // R1: reset state
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 cfg", 32'({wake_en_q, wake_pol_q}), 0);
    chk("R1 flags", 32'(wake_flags), 0);
    chk("R1 status", 32'({core_rst, in_shdn, io_frozen, exit_cause, shdn_rej}), 0);
    rst = 0;
    tick();

    // R2: pass-through
    for (int k = 0; k < 6; k++) begin
      logic [N-1:0] o, e;
      o = N'($urandom); e = N'($urandom);
      core_out = o; core_oe = e;
      tick();
      chk("R2 pad_out follow", 32'(pad_out), 32'(o));
      chk("R2 pad_oe follow", 32'(pad_oe), 32'(e));
    end

    // R12: ext and debug requests ignored while running
    ext_wake = 1; dbg_wake = 1;
    tick();
    ext_wake = 0; dbg_wake = 0;
    chk("R12 no wake in run", 32'({core_rst, in_shdn, exit_cause}), 0);

    for (int ep = 0; ep < 30; ep++) begin
      logic [N-1:0] en, pol, pins, m, co, coe, w, expf, clr, cn;
      int mode, n;
      en = N'($urandom); pol = N'($urandom);
      if (ep == 0) en = '0;
      cfg_wake_en = en; cfg_wake_pol = pol; cfg_we = 1;
      tick();
      cfg_we = 0;
      chk("R2 cfg load", 32'({wake_en_q, wake_pol_q}), 32'({en, pol}));

      pins = N'($urandom);
      if (ep == 1) pins = (pol & en) | (pins & ~en);
      pin_in = pins;
      m = match_of(en, pol, pins);
      if (m != '0) begin
        shdn_cmd = 1;
        tick();
        shdn_cmd = 0;
        chk("R4 refused stays run", 32'(in_shdn), 0);
        chk("R4 refuse flag", 32'(shdn_rej), 1);
        chk("R4 no freeze", 32'(io_frozen), 0);
      end

      pin_in = quiet_pins(en, pol, N'($urandom));
      co = N'($urandom); coe = N'($urandom);
      core_out = co; core_oe = coe; shdn_cmd = 1;
      tick();
      shdn_cmd = 0;
      chk("R3 enter shdn", 32'({in_shdn, io_frozen}), 32'b11);
      chk("R3 latched out", 32'(pad_out), 32'(co));
      chk("R3 latched oe", 32'(pad_oe), 32'(coe));
      chk("R4 accept clears", 32'(shdn_rej), 0);
      chk("R11 cfg cleared", 32'({wake_en_q, wake_pol_q}), 0);

      for (int k = 0; k < 4; k++) begin
        core_out = N'($urandom); core_oe = N'($urandom);
        pin_in = quiet_pins(en, pol, N'($urandom));
        cfg_wake_en = N'($urandom) | 1; cfg_wake_pol = N'($urandom); cfg_we = 1;
        io_release = 1;
        tick();
        cfg_we = 0; io_release = 0;
        chk("R5 stays asleep", 32'(in_shdn), 1);
        chk("R8 frozen out", 32'(pad_out), 32'(co));
        chk("R8 frozen oe", 32'(pad_oe), 32'(coe));
        chk("R8 release ignored", 32'(io_frozen), 1);
        chk("R11 write ignored", 32'({wake_en_q, wake_pol_q}), 0);
      end

      mode = int'($urandom % 3);
      if (en == '0 && mode == 0) mode = 1;
      expf = '0;
      if (mode == 0) begin
        w = en & N'($urandom);
        if (w == '0) w = en & (~en + 1'b1);
        pin_in = (~pol & en & ~w) | (pol & w) | (pin_in & ~en);
        expf = w;
      end else if (mode == 1) ext_wake = 1;
      else dbg_wake = 1;
      tick();
      ext_wake = 0; dbg_wake = 0;
      chk("R7 pulse starts", 32'(core_rst), 1);
      chk("R5 left shdn", 32'(in_shdn), 0);
      if (mode == 0) chk("R10 flags at wake", 32'(wake_flags), 32'(expf));
      else chk("R6 no flags", 32'(wake_flags), 0);
      chk("R9 cause set", 32'(exit_cause), 1);

      n = 1;
      shdn_cmd = 1; cfg_we = 1; core_out = N'($urandom);
      while (n < 40) begin
        tick();
        if (!core_rst) break;
        n++;
      end
      shdn_cmd = 0; cfg_we = 0;
      chk("R7 pulse length", 32'(n), RC);
      chk("R12 cmd ignored in reset", 32'(in_shdn), 0);
      chk("R11 cfg still clear", 32'({wake_en_q, wake_pol_q}), 0);
      chk("R8 frozen after reset", 32'({io_frozen, pad_out}), 32'({1'b1, co}));
      chk("R10 flags survive", 32'(wake_flags), 32'(expf));
      chk("R9 cause survives", 32'(exit_cause), 1);

      clr = N'($urandom);
      flag_clr = clr;
      tick();
      flag_clr = '0;
      chk("R10 partial clear", 32'(wake_flags), 32'(expf & ~clr));
      flag_clr = '1; cause_clr = 1;
      tick();
      flag_clr = '0; cause_clr = 0;
      chk("R10 all cleared", 32'(wake_flags), 0);
      chk("R9 cause cleared", 32'(exit_cause), 0);

      cn = ~co;
      core_out = cn; io_release = 1;
      tick();
      io_release = 0;
      chk("R8 release", 32'(io_frozen), 0);
      chk("R8 held on release edge", 32'(pad_out), 32'(co));
      tick();
      chk("R8 follows after release", 32'(pad_out), 32'(cn));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule